// File: doc/BRIEF.md
# Per-Process Page Table Translator

This block turns a 16-bit CPU address into a wider physical address through a page table held in on-chip storage. The table is indexed by the current process number together with the top bits of the CPU address, so every process owns a private set of sixteen 4 KB page mappings. Each entry supplies the physical frame that forms the high physical address bits. It also carries valid, write-permit and execute-permit flags. An access that the entry does not permit raises a fault.

Process 0 is the supervisor. Only the supervisor may load the process register or use the table window. The window is a separate strobe that addresses any entry of any process directly with the CPU's low address bits. This lets the supervisor build mappings for other processes, including mappings onto frames already in use elsewhere. A non-zero process that tries either operation is refused and sees a fault.

Translation is combinational from the registered process number and the present address. Table and process-register writes take effect at the next clock edge.

Top module: `pt_xlat`

## Requirements
- R1: After reset the process register reads 0 and every table entry is zero, so every translated access faults and a window read returns 0.
- R2: For a translated access (cpu_valid high, tbl_sel low) that does not fault, phys_addr equals the entry's frame followed by cpu_addr[11:0], with the result valid in the same cycle.
- R3: An entry is 11 bits: bit 10 valid, bit 9 execute permit, bit 8 write permit, bits 7:0 frame. A translated access to an entry whose valid bit is 0 raises fault.
- R4: A translated access with cpu_write high to an entry whose write-permit bit is 0 raises fault, and a read of the same entry does not.
- R5: A translated access with cpu_fetch high to an entry whose execute-permit bit is 0 raises fault.
- R6: When the process register is 0, tbl_sel with tbl_we writes tbl_wdata into entry cpu_addr[7:0], where that index is {process[3:0], page[3:0]}. The new value is visible from the next cycle. tbl_sel without tbl_we returns that entry on tbl_rdata in the same cycle.
- R7: When the process register is 0, pid_we loads pid_wdata, and cur_pid shows it from the next cycle.
- R8: When the process register is non-zero, pid_we leaves the register unchanged and raises fault in that cycle.
- R9: When the process register is non-zero, a table-window access leaves the table unchanged, returns 0 on tbl_rdata and raises fault in that cycle.
- R10: Two processes that use the same CPU page are translated through different entries and may reach different frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Translated CPU access in this cycle |
| cpu_write | input | 1 | The access is a store |
| cpu_fetch | input | 1 | The access is an instruction fetch |
| cpu_addr | input | 16 | CPU address; low 8 bits index the table during window access |
| pid_we | input | 1 | Load request for the process register |
| pid_wdata | input | 4 | New process number |
| tbl_sel | input | 1 | Table-window access in this cycle |
| tbl_we | input | 1 | Window access is a write |
| tbl_wdata | input | 11 | Entry value to store |
| tbl_rdata | output | 11 | Entry read through the window |
| phys_addr | output | 20 | Translated physical address |
| cur_pid | output | 4 | Current process number |
| fault | output | 1 | Refused or unpermitted access |

## Verification
The hardest situation to reach is a refused privileged operation, because once a non-zero process is loaded the ports offer no way back to the supervisor except reset. The stimulus therefore plans its tests so that each user-mode phase ends with a reset and a rebuilt table. A refused window write is made to target the user's own entry, so the translated address a cycle later shows whether the old frame survived. A long random phase then stays in process 0, mixing window writes, read-backs and translated accesses.

// File: rtl/pt_pkg.sv
package pt_pkg;
   // Flag field sits directly above the frame number in every entry.
   localparam int FLAG_W   = 3;
   localparam int F_VALID  = 2;
   localparam int F_EXEC   = 1;
   localparam int F_WRITE  = 0;
   localparam int MAX_ENT_W = 16;
endpackage

// File: rtl/pt_pid_reg.sv
module pt_pid_reg #(
   parameter int PID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PID_W-1:0] din,
   output logic [PID_W-1:0] pid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pid <= '0;
      else if (load) pid <= din;
   end
endmodule

// File: rtl/pt_table.sv
module pt_table #(
   parameter int IDX_W = 8,
   parameter int ENT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [ENT_W-1:0] wdata,
   output logic [ENT_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/pt_perm.sv
module pt_perm #(
   parameter bit EXEC_CHECK = 1'b1
) (
   input  logic [pt_pkg::FLAG_W-1:0] flags,
   input  logic                      access,
   input  logic                      is_write,
   input  logic                      is_fetch,
   output logic                      deny
);
   logic miss, wr_bad, ex_bad;

   assign miss   = !flags[pt_pkg::F_VALID];
   assign wr_bad = is_write && !flags[pt_pkg::F_WRITE];

   generate
      if (EXEC_CHECK) begin : g_exec
         assign ex_bad = is_fetch && !flags[pt_pkg::F_EXEC];
      end else begin : g_noexec
         assign ex_bad = 1'b0;
      end
   endgenerate

   assign deny = access && (miss || wr_bad || ex_bad);
endmodule

// File: rtl/pt_xlat.sv
module pt_xlat #(
   parameter int VA_W       = 16,
   parameter int PAGE_W     = 4,
   parameter int PID_W      = 4,
   parameter int FRAME_W    = 8,
   parameter bit EXEC_CHECK = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cpu_valid,
   input  logic                                  cpu_write,
   input  logic                                  cpu_fetch,
   input  logic [VA_W-1:0]                       cpu_addr,
   input  logic                                  pid_we,
   input  logic [PID_W-1:0]                      pid_wdata,
   input  logic                                  tbl_sel,
   input  logic                                  tbl_we,
   input  logic [FRAME_W+pt_pkg::FLAG_W-1:0]     tbl_wdata,
   output logic [FRAME_W+pt_pkg::FLAG_W-1:0]     tbl_rdata,
   output logic [FRAME_W+VA_W-PAGE_W-1:0]        phys_addr,
   output logic [PID_W-1:0]                      cur_pid,
   output logic                                  fault
);
   localparam int OFF_W = VA_W - PAGE_W;
   localparam int IDX_W = PID_W + PAGE_W;
   localparam int ENT_W = FRAME_W + pt_pkg::FLAG_W;

   generate
      if (ENT_W > pt_pkg::MAX_ENT_W) begin : g_bad_ent
         $error("pt_xlat: entry wider than 16 bits");
      end
      if (IDX_W > VA_W) begin : g_bad_idx
         $error("pt_xlat: window index wider than CPU address");
      end
      if (PAGE_W >= VA_W) begin : g_bad_page
         $error("pt_xlat: page field leaves no offset");
      end
   endgenerate

   logic             sup;
   logic             pid_load;
   logic             tab_we;
   logic [IDX_W-1:0] idx;
   logic [ENT_W-1:0] entry;
   logic             priv_bad;
   logic             deny;

   assign sup      = (cur_pid == '0);
   assign pid_load = pid_we && sup;
   assign tab_we   = tbl_sel && tbl_we && sup;
   assign idx      = tbl_sel ? cpu_addr[IDX_W-1:0]
                             : {cur_pid, cpu_addr[VA_W-1 -: PAGE_W]};

   pt_pid_reg #(.PID_W(PID_W)) u_pid (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (pid_load),
      .din   (pid_wdata),
      .pid   (cur_pid)
   );

   pt_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tab (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tab_we),
      .idx   (idx),
      .wdata (tbl_wdata),
      .rdata (entry)
   );

   pt_perm #(.EXEC_CHECK(EXEC_CHECK)) u_perm (
      .flags    (entry[ENT_W-1 -: pt_pkg::FLAG_W]),
      .access   (cpu_valid && !tbl_sel),
      .is_write (cpu_write),
      .is_fetch (cpu_fetch),
      .deny     (deny)
   );

   assign priv_bad  = !sup && (pid_we || tbl_sel);
   assign fault     = priv_bad || deny;
   assign tbl_rdata = (tbl_sel && sup) ? entry : '0;
   assign phys_addr = {entry[FRAME_W-1:0], cpu_addr[OFF_W-1:0]};
endmodule

// File: rtl/pt_xlat_chk.sv
module pt_xlat_chk #(
   parameter int VA_W    = 16,
   parameter int PID_W   = 4,
   parameter int ENT_W   = 11,
   parameter int IDX_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [VA_W-1:0]  cpu_addr,
   input logic             pid_we,
   input logic [PID_W-1:0] pid_wdata,
   input logic             tbl_sel,
   input logic             tbl_we,
   input logic [ENT_W-1:0] tbl_wdata,
   input logic [ENT_W-1:0] tbl_rdata,
   input logic [PID_W-1:0] cur_pid,
   input logic             fault
);
   // R7: supervisor load reaches the register on the next edge
   p_pid_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pid_we && cur_pid == '0) |=> (cur_pid == $past(pid_wdata)));

   // R8: a user process cannot move the process register
   p_pid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pid_we && cur_pid != '0) |=> $stable(cur_pid));

   // R8, R9: refused privileged operations are flagged
   p_priv_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pid_we || tbl_sel) && cur_pid != '0) |-> fault);

   // R9: a user window access reveals nothing
   p_user_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_sel && cur_pid != '0) |-> (tbl_rdata == '0));

   // R6: a supervisor write is read back from the same index next cycle
   p_wr_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_sel && tbl_we && cur_pid == '0 && !pid_we) |=>
      (!(tbl_sel && !tbl_we && cpu_addr[IDX_W-1:0] == $past(cpu_addr[IDX_W-1:0]))
       || tbl_rdata == $past(tbl_wdata)));
endmodule

bind pt_xlat pt_xlat_chk #(
   .VA_W  (VA_W),
   .PID_W (PID_W),
   .ENT_W (ENT_W),
   .IDX_W (IDX_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .pid_we    (pid_we),
   .pid_wdata (pid_wdata),
   .tbl_sel   (tbl_sel),
   .tbl_we    (tbl_we),
   .tbl_wdata (tbl_wdata),
   .tbl_rdata (tbl_rdata),
   .cur_pid   (cur_pid),
   .fault     (fault)
);

// File: tb/pt_xlat_tb_top.sv
module pt_xlat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 0, cpu_write = 0, cpu_fetch = 0;
   logic [15:0] cpu_addr = '0;
   logic        pid_we = 0;
   logic [3:0]  pid_wdata = '0;
   logic        tbl_sel = 0, tbl_we = 0;
   logic [10:0] tbl_wdata = '0;
   logic [10:0] tbl_rdata;
   logic [19:0] phys_addr;
   logic [3:0]  cur_pid;
   logic        fault;

   int vectors = 0;
   int miscompares = 0;

   // Behavioural reference state
   logic [10:0] mtab [0:255];
   int          mpid;

   always #4 clk = ~clk;

   pt_xlat dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_fetch(cpu_fetch),
      .cpu_addr(cpu_addr), .pid_we(pid_we), .pid_wdata(pid_wdata),
      .tbl_sel(tbl_sel), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
      .tbl_rdata(tbl_rdata), .phys_addr(phys_addr), .cur_pid(cur_pid),
      .fault(fault)
   );

   function automatic logic [10:0] ent(bit v, bit x, bit w, logic [7:0] fr);
      return {v, x, w, fr};
   endfunction

   task automatic idle();
      cpu_valid = 0; cpu_write = 0; cpu_fetch = 0;
      pid_we = 0; tbl_sel = 0; tbl_we = 0;
   endtask

   task automatic cmp(string req, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // Compare mid-cycle, then advance the model at the edge.
   task automatic tick(string req);
      logic [7:0]  idx;
      logic [10:0] e;
      bit          efault;
      @(negedge clk);
      idx = tbl_sel ? cpu_addr[7:0] : {mpid[3:0], cpu_addr[15:12]};
      e = mtab[idx];
      efault = (mpid != 0 && (pid_we || tbl_sel)) ||
               (cpu_valid && !tbl_sel &&
                (!e[10] || (cpu_write && !e[8]) || (cpu_fetch && !e[9])));
      cmp(req, "cur_pid", cur_pid, mpid);
      cmp(req, "fault", fault, efault);
      cmp(req, "tbl_rdata", tbl_rdata, (tbl_sel && mpid == 0) ? e : 11'h0);
      if (cpu_valid && !tbl_sel && !efault)
         cmp(req, "phys_addr", phys_addr, {e[7:0], cpu_addr[11:0]});
      @(posedge clk);
      if (rst_n) begin
         if (tbl_sel && tbl_we && mpid == 0) mtab[cpu_addr[7:0]] = tbl_wdata;
         if (pid_we && mpid == 0) mpid = pid_wdata;
      end
      #1;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      for (int i = 0; i < 256; i++) mtab[i] = '0;
      mpid = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic sup_write(logic [3:0] p, logic [3:0] pg, logic [10:0] v);
      idle(); tbl_sel = 1; tbl_we = 1; cpu_addr = {8'h00, p, pg}; tbl_wdata = v;
      tick("R6");
      idle();
   endtask

   task automatic sup_read(logic [3:0] p, logic [3:0] pg);
      idle(); tbl_sel = 1; cpu_addr = {8'h00, p, pg};
      tick("R6");
      idle();
   endtask

   task automatic acc(string req, logic [15:0] a, bit w, bit f);
      idle(); cpu_valid = 1; cpu_write = w; cpu_fetch = f; cpu_addr = a;
      tick(req);
      idle();
   endtask

   task automatic set_pid(string req, logic [3:0] p);
      idle(); pid_we = 1; pid_wdata = p;
      tick(req);
      idle();
   endtask

   initial begin
      #(8 * 150000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state, all accesses fault, window reads zero
      tick("R1");
      acc("R1", 16'h0123, 0, 0);
      acc("R1", 16'hF000, 1, 1);
      sup_read(4'h3, 4'h7);

      // R6: build tables for processes 0, 1 and 2
      sup_write(4'h0, 4'h0, ent(1, 1, 1, 8'h10));
      sup_write(4'h1, 4'h3, ent(1, 0, 0, 8'h22));
      sup_write(4'h1, 4'h4, ent(1, 1, 1, 8'h23));
      sup_write(4'h2, 4'h0, ent(1, 1, 1, 8'h44));
      sup_read(4'h1, 4'h3);
      sup_read(4'h2, 4'h0);
      // back-to-back write then read of the same index
      idle(); tbl_sel = 1; tbl_we = 1; cpu_addr = 16'h0015; tbl_wdata = ent(1, 0, 1, 8'h5A);
      tick("R6");
      tbl_we = 0;
      tick("R6");
      idle();

      // R2: supervisor translation with offset passthrough
      acc("R2", 16'h0ABC, 0, 0);
      acc("R2", 16'h0FFF, 1, 1);
      acc("R3", 16'h1000, 0, 0);

      // R7: supervisor moves to process 1
      set_pid("R7", 4'h1);
      tick("R7");
      acc("R2", 16'h3456, 0, 0);
      acc("R4", 16'h3456, 1, 0);
      acc("R5", 16'h3000, 0, 1);
      acc("R4", 16'h4321, 1, 1);
      acc("R3", 16'h5000, 0, 0);
      acc("R10", 16'h0010, 0, 0);

      // R8: user cannot change process number
      set_pid("R8", 4'h0);
      tick("R8");
      // R9: user window write to its own entry is ignored
      idle(); tbl_sel = 1; tbl_we = 1; cpu_addr = 16'h0013; tbl_wdata = ent(1, 1, 1, 8'h99);
      tick("R9");
      tbl_we = 0;
      tick("R9");
      idle();
      acc("R9", 16'h3777, 0, 0);

      // R10: process 2 reaches a different frame for page 0
      do_reset();
      sup_write(4'h0, 4'h0, ent(1, 1, 1, 8'h10));
      sup_write(4'h2, 4'h0, ent(1, 1, 1, 8'h44));
      acc("R10", 16'h0042, 0, 0);
      set_pid("R7", 4'h2);
      acc("R10", 16'h0042, 0, 0);
      acc("R3", 16'h2000, 0, 0);

      // Random supervisor traffic
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         int k;
         idle();
         k = $urandom_range(0, 3);
         cpu_addr = 16'($urandom);
         if (k == 0) begin
            tbl_sel = 1; tbl_we = 1; tbl_wdata = 11'($urandom);
            cpu_addr[7:4] = 4'($urandom_range(0, 1));
         end else if (k == 1) begin
            tbl_sel = 1;
            cpu_addr[7:4] = 4'($urandom_range(0, 1));
         end else begin
            cpu_valid = 1; cpu_write = 1'($urandom); cpu_fetch = 1'($urandom);
            pid_we = ($urandom_range(0, 7) == 0); pid_wdata = 4'h0;
         end
         tick("R2");
      end
      idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule